// File: doc/BRIEF.md
# Waveform Capture Channel

This block picks one internal signal stream from one phase of a three-phase metering front end and thins it to a programmed output rate. It holds each kept 24-bit sample for a host, which reads it as three bytes, most significant byte first. Five candidate streams feed it, all at the base rate and each carrying three phase lanes: current, voltage, active power, reactive power and apparent power. A single base-rate strobe marks new data on every lane. The block only observes these streams, so the energy paths that produce them are never touched.

When a kept sample is waiting and the interrupt is enabled, an active-low request line is pulled low. The host then issues one read strobe per byte. The request is released after the third byte unless another sample is queued. A sample that is kept while a read is in progress is parked and becomes the next sample once that read finishes. The rate field keeps every first, second, fourth or eighth base-rate sample. No filtering is applied.

Top module: `wave_capture_top`

## Requirements
- R1: `src_sel` codes 0 to 4 pick current, voltage, active power, reactive power and apparent power respectively. Codes 5 to 7 pick nothing, so no sample is kept.
- R2: `ph_sel` values 0, 1 and 2 pick the lane at bits [24k+23:24k] of each stream, with k equal to the value. Value 3 is reserved and no sample is kept.
- R3: A base strobe is kept when a counter of base strobes, cleared by reset and advanced on every strobe, has its low `rate_sel` bits all zero. This keeps every 2^`rate_sel`-th strobe, starting with the first after reset. The kept value equals the input lane unchanged.
- R4: With `irq_mask`=1, `irq_n` is low from the cycle after a sample is kept until it is read. With `irq_mask`=0, `irq_n` stays high, and a held sample pulls it low once the mask is set.
- R5: `rd_byte` shows bits [23:16] of the held sample, then [15:8] after one read strobe, then [7:0] after the second.
- R6: The third read strobe releases `irq_n` on the next cycle when no other sample is waiting.
- R7: A sample kept after the first byte of a read and before its end is parked. The ongoing read still returns the old bytes. After that read, `irq_n` stays low and the parked sample is read next.
- R8: A read strobe while no sample is held is ignored: the next sample is still read starting from its top byte.
- R9: A newly kept sample replaces a held sample whose read has not started.
- R10: After reset `irq_n` is high and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_valid | input | 1 | New data on all stream lanes this cycle |
| cur_in | input | 72 | Current lanes, phase k at [24k+23:24k] |
| volt_in | input | 72 | Voltage lanes |
| act_in | input | 72 | Active power lanes |
| react_in | input | 72 | Reactive power lanes |
| app_in | input | 72 | Apparent power lanes |
| src_sel | input | 3 | Source code |
| ph_sel | input | 2 | Phase code |
| rate_sel | input | 2 | Decimation exponent |
| irq_mask | input | 1 | Enables the ready request |
| rd_strobe | input | 1 | One byte consumed by the host |
| irq_n | output | 1 | Active-low sample-ready request |
| rd_byte | output | 8 | Byte currently offered to the host |

## Verification
The hardest case to reach from the ports is a sample kept after a read has begun and before it ends. That sample must be parked without corrupting the bytes already being shifted out. The stimulus reaches this case by issuing one read strobe, then a base strobe with new lane values, and then the remaining two strobes. It then checks that `irq_n` stays low and that the parked word comes out next. A second hard case is replacing an unread sample, which is reached by two kept strobes back to back with no read between them.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
    localparam int SMP_W    = 24;
    localparam int PHASES   = 3;
    localparam int SOURCES  = 5;
    localparam int RATE_W   = 2;

    typedef enum logic [2:0] {
        SRC_CUR   = 3'd0,
        SRC_VOLT  = 3'd1,
        SRC_ACT   = 3'd2,
        SRC_REACT = 3'd3,
        SRC_APP   = 3'd4
    } src_e;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] data;
    } samp_t;

    function automatic logic [RATE_W:0] dec_max(input int rw);
        return (RATE_W+1)'((1 << ((1 << rw) - 1)) - 1);
    endfunction
endpackage

// File: rtl/wcap_mux.sv
module wcap_mux
    import wcap_pkg::*;
#(
    parameter int DW  = SMP_W,
    parameter int NPH = PHASES
) (
    input  logic [NPH*DW-1:0] cur_in,
    input  logic [NPH*DW-1:0] volt_in,
    input  logic [NPH*DW-1:0] act_in,
    input  logic [NPH*DW-1:0] react_in,
    input  logic [NPH*DW-1:0] app_in,
    input  logic [2:0]        src_sel,
    input  logic [1:0]        ph_sel,
    output logic              sel_ok,
    output logic [DW-1:0]     sel_data
);
    logic [DW-1:0] lanes [SOURCES][NPH];

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        assign lanes[0][p] = cur_in  [p*DW +: DW];
        assign lanes[1][p] = volt_in [p*DW +: DW];
        assign lanes[2][p] = act_in  [p*DW +: DW];
        assign lanes[3][p] = react_in[p*DW +: DW];
        assign lanes[4][p] = app_in  [p*DW +: DW];
    end

    always_comb begin
        sel_ok   = (32'(src_sel) < SOURCES) && (32'(ph_sel) < NPH);
        sel_data = '0;
        for (int s = 0; s < SOURCES; s++)
            for (int p = 0; p < NPH; p++)
                if (32'(src_sel) == s && 32'(ph_sel) == p)
                    sel_data = lanes[s][p];
    end
endmodule

// File: rtl/wcap_decim.sv
module wcap_decim
    import wcap_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_valid,
    input  logic          sel_ok,
    input  logic [RW-1:0] rate_sel,
    output logic          keep
);
    localparam int CW = (1 << RW) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] msk;

    always_comb begin
        msk = '0;
        for (int i = 0; i < CW; i++)
            if (i < 32'(rate_sel)) msk[i] = 1'b1;
        keep = base_valid && sel_ok && ((cnt_q & msk) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (base_valid) cnt_q <= cnt_q + 1'b1;
    end

    // R3: with a nonzero rate and a steady rate field, kept samples never touch
    a_r3_gap: assert property (@(posedge clk) disable iff (rst)
        (keep && rate_sel != '0) |=> (!keep || rate_sel != $past(rate_sel)));
endmodule

// File: rtl/wcap_reader.sv
module wcap_reader
    import wcap_pkg::*;
#(
    parameter int DW = SMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          keep,
    input  logic [DW-1:0] keep_data,
    input  logic          rd_strobe,
    output logic          ready,
    output logic [7:0]    rd_byte
);
    localparam int NB   = DW / 8;
    localparam int IW   = $clog2(NB);
    localparam int LAST = NB - 1;

    samp_t         cur_q, pend_q;
    logic [IW-1:0] idx_q;
    logic          rd_fire, last_rd, mid;
    logic [DW-1:0] shifted;

    always_comb begin
        rd_fire = rd_strobe && cur_q.vld;
        last_rd = rd_fire && (32'(idx_q) == LAST);
        mid     = (idx_q != '0) || rd_fire;
        shifted = cur_q.data >> (8 * (LAST - 32'(idx_q)));
        rd_byte = shifted[7:0];
        ready   = cur_q.vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            pend_q <= '0;
            idx_q  <= '0;
        end else if (last_rd) begin
            idx_q      <= '0;
            pend_q.vld <= 1'b0;
            if (keep)            cur_q <= '{vld: 1'b1, data: keep_data};
            else if (pend_q.vld) cur_q <= pend_q;
            else                 cur_q.vld <= 1'b0;
        end else begin
            if (rd_fire) idx_q <= idx_q + 1'b1;
            if (keep) begin
                if (mid) pend_q <= '{vld: 1'b1, data: keep_data};
                else     cur_q  <= '{vld: 1'b1, data: keep_data};
            end
        end
    end

    // R6: final byte with nothing waiting releases the sample
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (last_rd && !keep && !pend_q.vld) |=> !cur_q.vld);
    // R7: a sample kept during a read is parked and the read continues
    a_r7_park: assert property (@(posedge clk) disable iff (rst)
        (keep && mid && !last_rd) |=> (pend_q.vld && cur_q.vld));
    // R5: byte index stays within the sample
    a_r5_index: assert property (@(posedge clk) disable iff (rst)
        32'(idx_q) <= LAST);
    // R8: strobes with nothing held leave the read state untouched
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        (!cur_q.vld && !keep) |=> (idx_q == '0 && $stable(cur_q.data)));
endmodule

// File: rtl/wave_capture_top.sv
module wave_capture_top
    import wcap_pkg::*;
#(
    parameter int DW  = SMP_W,
    parameter int NPH = PHASES,
    parameter int RW  = RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_valid,
    input  logic [NPH*DW-1:0] cur_in,
    input  logic [NPH*DW-1:0] volt_in,
    input  logic [NPH*DW-1:0] act_in,
    input  logic [NPH*DW-1:0] react_in,
    input  logic [NPH*DW-1:0] app_in,
    input  logic [2:0]        src_sel,
    input  logic [1:0]        ph_sel,
    input  logic [RW-1:0]     rate_sel,
    input  logic              irq_mask,
    input  logic              rd_strobe,
    output logic              irq_n,
    output logic [7:0]        rd_byte
);
    logic          sel_ok, keep, ready;
    logic [DW-1:0] sel_data;

    wcap_mux #(.DW(DW), .NPH(NPH)) u_mux (
        .cur_in(cur_in), .volt_in(volt_in), .act_in(act_in),
        .react_in(react_in), .app_in(app_in),
        .src_sel(src_sel), .ph_sel(ph_sel),
        .sel_ok(sel_ok), .sel_data(sel_data)
    );

    wcap_decim #(.RW(RW)) u_dec (
        .clk(clk), .rst(rst), .base_valid(base_valid),
        .sel_ok(sel_ok), .rate_sel(rate_sel), .keep(keep)
    );

    wcap_reader #(.DW(DW)) u_rd (
        .clk(clk), .rst(rst), .keep(keep), .keep_data(sel_data),
        .rd_strobe(rd_strobe), .ready(ready), .rd_byte(rd_byte)
    );

    assign irq_n = !(ready && irq_mask);

    // R4: a kept sample with the mask set pulls the request low next cycle
    a_r4_raise: assert property (@(posedge clk) disable iff (rst)
        (keep && irq_mask) |=> (!irq_n || !irq_mask));
    // R2: reserved phase never produces a kept sample
    a_r2_reserved: assert property (@(posedge clk) disable iff (rst)
        (32'(ph_sel) >= NPH) |-> !keep);
endmodule

// File: tb/sim_wave_capture_top.sv
module sim_wave_capture_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_valid = 1'b0;
    logic [71:0] cur_in = '0, volt_in = '0, act_in = '0, react_in = '0, app_in = '0;
    logic [2:0]  src_sel = '0;
    logic [1:0]  ph_sel = '0;
    logic [1:0]  rate_sel = '0;
    logic        irq_mask = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        irq_n;
    logic [7:0]  rd_byte;

    int n_run = 0, n_fail = 0;
    logic [23:0] exp_q[$];
    logic [2:0]  bcnt;
    bit          mid_read;

    always #10 clk = ~clk;

    wave_capture_top u0 (
        .clk(clk), .rst(rst), .base_valid(base_valid),
        .cur_in(cur_in), .volt_in(volt_in), .act_in(act_in),
        .react_in(react_in), .app_in(app_in),
        .src_sel(src_sel), .ph_sel(ph_sel), .rate_sel(rate_sel),
        .irq_mask(irq_mask), .rd_strobe(rd_strobe),
        .irq_n(irq_n), .rd_byte(rd_byte)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] lane_val(input int s, input int p, input int seed);
        return {4'(s), 4'(p), 16'(seed * 16'h1357 + 16'h2468)};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        bcnt = '0; mid_read = 0; exp_q.delete();
    endtask

    // driver: one base strobe, models the kept sample and pushes it
    task automatic base_tick(input int seed, input string tag);
        logic [2:0] msk;
        for (int p = 0; p < 3; p++) begin
            cur_in  [p*24 +: 24] = lane_val(0, p, seed);
            volt_in [p*24 +: 24] = lane_val(1, p, seed);
            act_in  [p*24 +: 24] = lane_val(2, p, seed);
            react_in[p*24 +: 24] = lane_val(3, p, seed);
            app_in  [p*24 +: 24] = lane_val(4, p, seed);
        end
        msk = 3'((1 << rate_sel) - 1);
        base_valid = 1'b1;
        if (src_sel < 5 && ph_sel < 3 && (bcnt & msk) == 0) begin
            if (mid_read) begin
                if (exp_q.size() > 1) void'(exp_q.pop_back());
            end else exp_q.delete();
            exp_q.push_back(lane_val(src_sel, ph_sel, seed));
        end
        bcnt = bcnt + 1'b1;
        @(negedge clk);
        base_valid = 1'b0;
        chk(irq_n == !(exp_q.size() > 0 && irq_mask), tag, irq_n,
            !(exp_q.size() > 0 && irq_mask));
    endtask

    task automatic rd_one(input logic [23:0] w, input int k, input string tag);
        logic [7:0] e;
        e = 8'(w >> (8 * (2 - k)));
        chk(rd_byte == e, tag, rd_byte, e);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // monitor: pops the expected word and compares all three bytes
    task automatic read_sample(input string tag);
        logic [23:0] w;
        chk(exp_q.size() > 0, {tag, " pending"}, exp_q.size(), 1);
        if (exp_q.size() == 0) return;
        w = exp_q[0];
        for (int k = 0; k < 3; k++) rd_one(w, k, tag);
        void'(exp_q.pop_front());
        chk(irq_n == !(exp_q.size() > 0), {tag, " R6 release"}, irq_n, !(exp_q.size() > 0));
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 50000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] w;
        do_reset();
        chk(irq_n == 1'b1, "R10 irq_n", irq_n, 1);
        chk(rd_byte == 8'h00, "R10 rd_byte", rd_byte, 0);

        // R8: strobe with nothing held, then a full read from the top byte
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        chk(irq_n == 1'b1, "R8 idle", irq_n, 1);
        base_tick(7, "R8 tick");
        read_sample("R8 R5 read");

        // R1 / R2: every valid source and phase at full rate
        for (int s = 0; s < 5; s++)
            for (int p = 0; p < 3; p++) begin
                src_sel = 3'(s); ph_sel = 2'(p);
                base_tick(s * 3 + p, "R1 R2 tick");
                read_sample("R1 R2 R5 read");
            end

        // R1: reserved source codes keep nothing
        ph_sel = 2'd0;
        for (int s = 5; s < 8; s++) begin
            src_sel = 3'(s);
            base_tick(40 + s, "R1 reserved");
        end
        // R2: reserved phase keeps nothing
        src_sel = 3'd1; ph_sel = 2'd3;
        base_tick(50, "R2 reserved");

        // R3: each rate over eight strobes
        for (int r = 0; r < 4; r++) begin
            do_reset();
            src_sel = 3'd2; ph_sel = 2'd1; rate_sel = 2'(r);
            for (int t = 0; t < 8; t++) begin
                base_tick(100 + r * 8 + t, "R3 decimation");
                if (exp_q.size() > 0) read_sample("R3 read");
            end
        end
        rate_sel = 2'd0;

        // R4: masked request stays high, unmasking exposes the held sample
        irq_mask = 1'b0;
        base_tick(200, "R4 masked");
        @(negedge clk);
        chk(irq_n == 1'b1, "R4 masked hold", irq_n, 1);
        irq_mask = 1'b1;
        @(negedge clk);
        chk(irq_n == 1'b0, "R4 unmask", irq_n, 0);
        read_sample("R4 read");

        // R9: unread sample replaced by a newer one
        base_tick(210, "R9 first");
        base_tick(211, "R9 second");
        read_sample("R9 read");

        // R7: sample arriving mid-read is parked
        base_tick(220, "R7 first");
        w = exp_q[0];
        rd_one(w, 0, "R7 byte0");
        mid_read = 1;
        base_tick(221, "R7 tick");
        rd_one(w, 1, "R7 byte1");
        rd_one(w, 2, "R7 byte2");
        mid_read = 0;
        void'(exp_q.pop_front());
        chk(irq_n == 1'b0, "R7 still pending", irq_n, 0);
        read_sample("R7 parked read");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule